// File: doc/BRIEF.md
# Multiplexed MDIO Management Master

This block is a management-interface master with a register port. Software places a transaction description in the configuration word: which segment, which PHY, clause 22 or clause 45, and the data to write. It places the register address in a second register and starts the transaction with an operation code. One serial engine then generates the MDC clock and the MDIO frame. The engine is steered onto exactly one of several internal or external bus segments. When the serial transfer ends, the block raises a done flag, and for a read it captures the 16 returned bits.

The register port is a plain 32-bit single-cycle bus. Writes take effect on the clock edge where the write strobe is high. Reads are combinational from the address. Each segment class has its own MDC rate setting, so internal and external segments may run at different speeds. A lockout bit is exported so that any external management master can be held off the bus.

Top module: `mdio_mux_master`

## Requirements
- R1: After reset every register reads 0, the status done bit (status bit 0) is 0, `ext_lockout` is 0, and every segment has MDC low and its output enable low.
- R2: The external rate (offset 0x000), internal rate (0x004), scan control (0x008), configuration (0x23C) and address (0x244) registers read back what was written. Scan control bit 28 drives `ext_lockout`.
- R3: Writing 1 to the control register (0x248) starts a write. With configuration bit 21 clear, the block sends one 64-bit clause-22 frame, MSB first: 32 ones, 01, 01, PHY address (configuration bits 20:16), register address (address bits 4:0), 10, then write data (configuration bits 15:0). Every bit is driven.
- R4: Writing 2 to the control register starts a read. A clause-22 read frame uses opcode 10. The output enable is low for the two turnaround bits and the 16 data bits. The 16 bits sampled on the rising MDC edges of the data phase appear, first bit in bit 15, in the read-data register (0x240), and its bits 31:16 read 0.
- R5: With configuration bit 21 set, the block sends two frames, both with start 00. The first is an address frame with opcode 00, carrying address bits 15:0 as data. The second has opcode 01 (write) or 11 (read). Both frames use the PHY address from configuration bits 20:16 and the device address from address bits 20:16.
- R6: The done bit (status bit 0) becomes 1 once the last frame ends. Writing 0 to the control register while idle returns it to 0. Done is never 1 while a transaction is in flight.
- R7: Configuration bit 25 selects the segment class (1 internal, 0 external) and bits 24:22 select the segment number. Only that segment shows MDC activity and an asserted output enable; all others keep MDC low and their enable low. Read data is taken only from the selected segment's input.
- R8: MDC starts low, and each half period lasts max(D,1)*(M+1) core clocks. D is bits 15:0 and M is bits 23:16 of the rate register of the selected class. A frame has exactly 64 rising MDC edges. Output data changes only together with a falling edge.
- R9: A control write while a transaction is in flight, and a control write of any value other than 0, 1 or 2, has no effect. The transaction in flight completes unchanged, and no new one starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| ext_lockout | output | 1 | Holds any external management master off the bus |
| int_mdc | output | N_INT | MDC per internal segment |
| int_mdio_o | output | N_INT | MDIO output value per internal segment |
| int_mdio_oe | output | N_INT | MDIO output enable per internal segment |
| int_mdio_i | input | N_INT | MDIO input per internal segment |
| ext_mdc | output | N_EXT | MDC per external segment |
| ext_mdio_o | output | N_EXT | MDIO output value per external segment |
| ext_mdio_oe | output | N_EXT | MDIO output enable per external segment |
| ext_mdio_i | input | N_EXT | MDIO input per external segment |

## Verification
The properties assume that the register port carries at most one write per cycle. They also assume that software polls done instead of timing the transaction itself. The bench always programs the configuration, address and rate registers before the control write. It never changes them while a transaction is in flight, except for the deliberate control writes that test R9. The responder drives read bits only after a falling MDC edge on the selected segment and drives the inverse level on every other segment, so any wrong input steering shows up in the captured data.

// File: rtl/mdio_mm_pkg.sv
package mdio_mm_pkg;

   localparam int unsigned OFS_RATE_EXT = 32'h000;
   localparam int unsigned OFS_RATE_INT = 32'h004;
   localparam int unsigned OFS_SCAN     = 32'h008;
   localparam int unsigned OFS_CFG      = 32'h23C;
   localparam int unsigned OFS_RDATA    = 32'h240;
   localparam int unsigned OFS_MADDR    = 32'h244;
   localparam int unsigned OFS_CTRL     = 32'h248;
   localparam int unsigned OFS_STATUS   = 32'h24C;

   localparam int unsigned SEG_ID_W     = 3;
   localparam int unsigned FRAME_BITS   = 64;
   localparam int unsigned RELEASE_BITS = 18;
   localparam int unsigned LOCK_BIT     = 28;

   // configuration word layout (bits 25:0)
   typedef struct packed {
      logic                int_sel;
      logic [SEG_ID_W-1:0] seg;
      logic                c45;
      logic [4:0]          phy;
      logic [15:0]         wdata;
   } cfg_word_t;

   function automatic logic [FRAME_BITS-1:0] mk_frame(
      input logic [1:0]  st,
      input logic [1:0]  op,
      input logic [4:0]  pa,
      input logic [4:0]  ra,
      input logic [15:0] d);
      return {32'hFFFF_FFFF, st, op, pa, ra, 2'b10, d};
   endfunction

   function automatic logic [FRAME_BITS-1:0] mk_oe(input logic rd);
      return rd ? ({FRAME_BITS{1'b1}} << RELEASE_BITS) : {FRAME_BITS{1'b1}};
   endfunction

endpackage

// File: rtl/mdio_mm_regs.sv
module mdio_mm_regs
   import mdio_mm_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [31:0]       rate_ext_q,
   output logic [31:0]       rate_int_q,
   output logic [31:0]       scan_q,
   output logic [31:0]       cfg_q,
   output logic [31:0]       maddr_q,
   output logic              go,
   output logic              go_rd,
   input  logic              busy,
   input  logic              fin,
   input  logic              fin_rd,
   input  logic [15:0]       rx,
   output logic              done_q
);

   logic        hit_ctrl;
   logic        op_valid;
   logic        clr;
   logic [15:0] rdd_q;
   logic [1:0]  ctrl_q;

   if (ADDR_W < 10) begin : g_bad_addr
      $error("ADDR_W too narrow for register map");
   end

   assign hit_ctrl = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
   assign op_valid = (bus_wdata == 32'd1) || (bus_wdata == 32'd2);
   assign go       = hit_ctrl && !busy && op_valid;
   assign go_rd    = go && bus_wdata[1];
   assign clr      = hit_ctrl && !busy && (bus_wdata == 32'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_ext_q <= '0;
         rate_int_q <= '0;
         scan_q     <= '0;
         cfg_q      <= '0;
         maddr_q    <= '0;
         rdd_q      <= '0;
         ctrl_q     <= '0;
         done_q     <= 1'b0;
      end else begin
         if (bus_we) begin
            if (bus_addr == ADDR_W'(OFS_RATE_EXT)) rate_ext_q <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_RATE_INT)) rate_int_q <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_SCAN))     scan_q     <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_CFG))      cfg_q      <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_MADDR))    maddr_q    <= bus_wdata;
         end
         if (fin) begin
            done_q <= 1'b1;
            if (fin_rd) rdd_q <= rx;
         end
         if (go) begin
            done_q <= 1'b0;
            ctrl_q <= bus_wdata[1:0];
         end
         if (clr) begin
            done_q <= 1'b0;
            ctrl_q <= 2'b00;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_W'(OFS_RATE_EXT): bus_rdata = rate_ext_q;
         ADDR_W'(OFS_RATE_INT): bus_rdata = rate_int_q;
         ADDR_W'(OFS_SCAN):     bus_rdata = scan_q;
         ADDR_W'(OFS_CFG):      bus_rdata = cfg_q;
         ADDR_W'(OFS_RDATA):    bus_rdata = {16'h0, rdd_q};
         ADDR_W'(OFS_MADDR):    bus_rdata = maddr_q;
         ADDR_W'(OFS_CTRL):     bus_rdata = {30'h0, ctrl_q};
         ADDR_W'(OFS_STATUS):   bus_rdata = {31'h0, done_q};
         default:               bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/mdio_mm_rate.sv
module mdio_mm_rate #(
   parameter int DIV_W = 16,
   parameter int DVD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   input  logic [DVD_W-1:0] dvd,
   output logic             tick
);

   logic [DIV_W-1:0] pre_q;
   logic [DVD_W-1:0] post_q;
   logic [DIV_W-1:0] pre_lim;
   logic             pre_wrap;

   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
      $error("DIV_W must be 1..16");
   end
   if (DVD_W < 1 || DVD_W > 16) begin : g_bad_dvd
      $error("DVD_W must be 1..16");
   end

   assign pre_lim  = (div == '0) ? '0 : div - 1'b1;
   assign pre_wrap = (pre_q == pre_lim);
   assign tick     = en && pre_wrap && (post_q == dvd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         post_q <= '0;
      end else if (!en) begin
         pre_q  <= '0;
         post_q <= '0;
      end else if (pre_wrap) begin
         pre_q  <= '0;
         post_q <= (post_q == dvd) ? '0 : post_q + 1'b1;
      end else begin
         pre_q  <= pre_q + 1'b1;
      end
   end

endmodule

// File: rtl/mdio_mm_frame.sv
module mdio_mm_frame
   import mdio_mm_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go,
   input  logic                go_rd,
   input  cfg_word_t           cfg,
   input  logic [20:0]         maddr,
   input  logic                tick,
   input  logic                mdi,
   output logic                run,
   output logic                seg_int,
   output logic [SEG_ID_W-1:0] seg_id,
   output logic                mdc,
   output logic                mdo,
   output logic                mdoe,
   output logic                fin,
   output logic                fin_rd,
   output logic [15:0]         rx
);

   localparam int CNT_W = $clog2(FRAME_BITS);
   localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] DATA_BIT0 = CNT_W'(FRAME_BITS - 16);

   logic [FRAME_BITS-1:0] word_q;
   logic [FRAME_BITS-1:0] oe_q;
   logic [CNT_W-1:0]      bit_q;
   logic                  hi_q;
   logic                  pend_q;
   logic                  rd_q;
   logic                  rdfr_q;
   logic [4:0]            phy_q;
   logic [4:0]            dev_q;
   logic [15:0]           wd_q;

   assign mdo  = word_q[FRAME_BITS-1];
   assign mdoe = run && oe_q[FRAME_BITS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run     <= 1'b0;
         seg_int <= 1'b0;
         seg_id  <= '0;
         mdc     <= 1'b0;
         fin     <= 1'b0;
         fin_rd  <= 1'b0;
         rx      <= '0;
         word_q  <= '0;
         oe_q    <= '0;
         bit_q   <= '0;
         hi_q    <= 1'b0;
         pend_q  <= 1'b0;
         rd_q    <= 1'b0;
         rdfr_q  <= 1'b0;
         phy_q   <= '0;
         dev_q   <= '0;
         wd_q    <= '0;
      end else begin
         fin    <= 1'b0;
         fin_rd <= 1'b0;
         if (!run) begin
            mdc <= 1'b0;
            if (go) begin
               run     <= 1'b1;
               seg_int <= cfg.int_sel;
               seg_id  <= cfg.seg;
               rd_q    <= go_rd;
               phy_q   <= cfg.phy;
               dev_q   <= maddr[20:16];
               wd_q    <= cfg.wdata;
               bit_q   <= '0;
               hi_q    <= 1'b0;
               rx      <= '0;
               if (cfg.c45) begin
                  word_q <= mk_frame(2'b00, 2'b00, cfg.phy, maddr[20:16], maddr[15:0]);
                  oe_q   <= mk_oe(1'b0);
                  rdfr_q <= 1'b0;
                  pend_q <= 1'b1;
               end else begin
                  word_q <= mk_frame(2'b01, go_rd ? 2'b10 : 2'b01, cfg.phy,
                                     maddr[4:0], go_rd ? 16'h0 : cfg.wdata);
                  oe_q   <= mk_oe(go_rd);
                  rdfr_q <= go_rd;
                  pend_q <= 1'b0;
               end
            end
         end else if (tick) begin
            if (!hi_q) begin
               mdc  <= 1'b1;
               hi_q <= 1'b1;
               if (rdfr_q && bit_q >= DATA_BIT0) rx <= {rx[14:0], mdi};
            end else begin
               mdc  <= 1'b0;
               hi_q <= 1'b0;
               if (bit_q == LAST_BIT) begin
                  bit_q <= '0;
                  if (pend_q) begin
                     pend_q <= 1'b0;
                     word_q <= mk_frame(2'b00, rd_q ? 2'b11 : 2'b01, phy_q, dev_q,
                                        rd_q ? 16'h0 : wd_q);
                     oe_q   <= mk_oe(rd_q);
                     rdfr_q <= rd_q;
                  end else begin
                     run    <= 1'b0;
                     fin    <= 1'b1;
                     fin_rd <= rd_q;
                  end
               end else begin
                  bit_q  <= bit_q + 1'b1;
                  word_q <= {word_q[FRAME_BITS-2:0], 1'b0};
                  oe_q   <= {oe_q[FRAME_BITS-2:0], 1'b1};
               end
            end
         end
      end
   end

endmodule

// File: rtl/mdio_mm_steer.sv
module mdio_mm_steer
   import mdio_mm_pkg::*;
#(
   parameter int N_INT = 8,
   parameter int N_EXT = 8
) (
   input  logic                active,
   input  logic                seg_int,
   input  logic [SEG_ID_W-1:0] seg_id,
   input  logic                mdc,
   input  logic                mdo,
   input  logic                mdoe,
   output logic [N_INT-1:0]    int_mdc,
   output logic [N_INT-1:0]    int_o,
   output logic [N_INT-1:0]    int_oe,
   input  logic [N_INT-1:0]    int_i,
   output logic [N_EXT-1:0]    ext_mdc,
   output logic [N_EXT-1:0]    ext_o,
   output logic [N_EXT-1:0]    ext_oe,
   input  logic [N_EXT-1:0]    ext_i,
   output logic                mdi
);

   logic [N_INT-1:0] hit_int;
   logic [N_EXT-1:0] hit_ext;

   for (genvar i = 0; i < N_INT; i++) begin : g_int
      assign hit_int[i] = active && seg_int && (seg_id == SEG_ID_W'(i));
      assign int_mdc[i] = hit_int[i] && mdc;
      assign int_o[i]   = hit_int[i] && mdo;
      assign int_oe[i]  = hit_int[i] && mdoe;
   end

   for (genvar j = 0; j < N_EXT; j++) begin : g_ext
      assign hit_ext[j] = active && !seg_int && (seg_id == SEG_ID_W'(j));
      assign ext_mdc[j] = hit_ext[j] && mdc;
      assign ext_o[j]   = hit_ext[j] && mdo;
      assign ext_oe[j]  = hit_ext[j] && mdoe;
   end

   assign mdi = (|(hit_int & int_i)) | (|(hit_ext & ext_i));

endmodule

// File: rtl/mdio_mux_master.sv
module mdio_mux_master
   import mdio_mm_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int N_INT  = 8,
   parameter int N_EXT  = 8,
   parameter int DIV_W  = 16,
   parameter int DVD_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              ext_lockout,
   output logic [N_INT-1:0]  int_mdc,
   output logic [N_INT-1:0]  int_mdio_o,
   output logic [N_INT-1:0]  int_mdio_oe,
   input  logic [N_INT-1:0]  int_mdio_i,
   output logic [N_EXT-1:0]  ext_mdc,
   output logic [N_EXT-1:0]  ext_mdio_o,
   output logic [N_EXT-1:0]  ext_mdio_oe,
   input  logic [N_EXT-1:0]  ext_mdio_i
);

   localparam int MAX_SEG = 1 << SEG_ID_W;
   localparam int CFG_W   = $bits(cfg_word_t);

   if (N_INT < 1 || N_INT > MAX_SEG) begin : g_bad_int
      $error("N_INT out of range");
   end
   if (N_EXT < 1 || N_EXT > MAX_SEG) begin : g_bad_ext
      $error("N_EXT out of range");
   end

   logic [31:0]         rate_ext_q, rate_int_q, scan_q, cfg_q, maddr_q;
   logic                go, go_rd, fin, fin_rd, st_done;
   logic                eng_run, eng_busy, tick;
   logic                seg_int, mdc, mdo, mdoe, mdi;
   logic [SEG_ID_W-1:0] seg_id;
   logic [15:0]         rx;
   logic [31:0]         rate_sel;

   assign eng_busy    = eng_run || fin;
   assign ext_lockout = scan_q[LOCK_BIT];
   assign rate_sel    = seg_int ? rate_int_q : rate_ext_q;

   mdio_mm_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rate_ext_q(rate_ext_q), .rate_int_q(rate_int_q), .scan_q(scan_q),
      .cfg_q(cfg_q), .maddr_q(maddr_q), .go(go), .go_rd(go_rd),
      .busy(eng_busy), .fin(fin), .fin_rd(fin_rd), .rx(rx), .done_q(st_done)
   );

   mdio_mm_rate #(.DIV_W(DIV_W), .DVD_W(DVD_W)) u_rate (
      .clk(clk), .rst_n(rst_n), .en(eng_run),
      .div(rate_sel[DIV_W-1:0]), .dvd(rate_sel[16 +: DVD_W]), .tick(tick)
   );

   mdio_mm_frame u_frame (
      .clk(clk), .rst_n(rst_n), .go(go), .go_rd(go_rd),
      .cfg(cfg_word_t'(cfg_q[CFG_W-1:0])), .maddr(maddr_q[20:0]),
      .tick(tick), .mdi(mdi), .run(eng_run), .seg_int(seg_int),
      .seg_id(seg_id), .mdc(mdc), .mdo(mdo), .mdoe(mdoe),
      .fin(fin), .fin_rd(fin_rd), .rx(rx)
   );

   mdio_mm_steer #(.N_INT(N_INT), .N_EXT(N_EXT)) u_steer (
      .active(eng_run), .seg_int(seg_int), .seg_id(seg_id),
      .mdc(mdc), .mdo(mdo), .mdoe(mdoe),
      .int_mdc(int_mdc), .int_o(int_mdio_o), .int_oe(int_mdio_oe), .int_i(int_mdio_i),
      .ext_mdc(ext_mdc), .ext_o(ext_mdio_o), .ext_oe(ext_mdio_oe), .ext_i(ext_mdio_i),
      .mdi(mdi)
   );

endmodule

// File: rtl/mdio_mux_master_chk.sv
module mdio_mux_master_chk
   import mdio_mm_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int N_INT  = 8,
   parameter int N_EXT  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              eng_busy,
   input logic              st_done,
   input logic [N_INT-1:0]  int_mdc,
   input logic [N_INT-1:0]  int_mdio_oe,
   input logic [N_EXT-1:0]  ext_mdc,
   input logic [N_EXT-1:0]  ext_mdio_oe
);

   logic ctrl_wr;
   assign ctrl_wr = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));

   a_r7_one_segment: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({int_mdc | int_mdio_oe, ext_mdc | ext_mdio_oe}));

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_busy |-> (int_mdc == '0 && ext_mdc == '0 && int_mdio_oe == '0 && ext_mdio_oe == '0));

   a_r6_busy_excl_done: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |-> !st_done);

   a_r6_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && bus_wdata == 32'd0 && !eng_busy) |=> !st_done);

   a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_done) |-> $past(eng_busy));

endmodule

bind mdio_mux_master mdio_mux_master_chk #(
   .ADDR_W(ADDR_W), .N_INT(N_INT), .N_EXT(N_EXT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .eng_busy(eng_busy), .st_done(st_done),
   .int_mdc(int_mdc), .int_mdio_oe(int_mdio_oe),
   .ext_mdc(ext_mdc), .ext_mdio_oe(ext_mdio_oe)
);

// File: tb/tb_mdio_mux_master.sv
`timescale 1ns/1ps
module tb_mdio_mux_master;

   localparam int AW = 12;
   localparam int NS = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          ext_lockout;
   logic [NS-1:0] int_mdc, int_mdio_o, int_mdio_oe;
   logic [NS-1:0] ext_mdc, ext_mdio_o, ext_mdio_oe;
   logic [NS-1:0] int_mdio_i = '0;
   logic [NS-1:0] ext_mdio_i = '0;

   int unsigned vectors = 0;
   int unsigned fails = 0;
   int unsigned cyc = 0;

   always #2.5 clk = ~clk;

   mdio_mux_master #(.ADDR_W(AW), .N_INT(NS), .N_EXT(NS)) dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_lockout(ext_lockout),
      .int_mdc(int_mdc), .int_mdio_o(int_mdio_o), .int_mdio_oe(int_mdio_oe),
      .int_mdio_i(int_mdio_i), .ext_mdc(ext_mdc), .ext_mdio_o(ext_mdio_o),
      .ext_mdio_oe(ext_mdio_oe), .ext_mdio_i(ext_mdio_i)
   );

   // ---------------- monitor and responder ----------------
   logic        mon_int = 1'b1;
   int          mon_id = 0;
   logic [15:0] rv = '0;
   int          nrise = 0;
   int          nhigh = 0;
   logic        quiet_bad = 1'b0;
   logic        pm = 1'b0;
   logic        cap_o [0:127];
   logic        cap_oe[0:127];

   always @(negedge clk) begin
      logic m, o, e, b;
      int k;
      m = mon_int ? int_mdc[mon_id]     : ext_mdc[mon_id];
      o = mon_int ? int_mdio_o[mon_id]  : ext_mdio_o[mon_id];
      e = mon_int ? int_mdio_oe[mon_id] : ext_mdio_oe[mon_id];
      if (m && !pm) begin
         if (nrise < 128) begin
            cap_o[nrise]  = o;
            cap_oe[nrise] = e;
         end
         nrise++;
      end
      if (m) nhigh++;
      if (!m && pm) begin
         k = nrise % 64;
         if (k >= 48) begin
            b = rv[63-k];
            int_mdio_i = {NS{~b}};
            ext_mdio_i = {NS{~b}};
            if (mon_int) int_mdio_i[mon_id] = b;
            else         ext_mdio_i[mon_id] = b;
         end
      end
      pm = m;
      for (int s = 0; s < NS; s++) begin
         if ((int_mdc[s] || int_mdio_oe[s]) && !(mon_int && s == mon_id)) quiet_bad = 1'b1;
         if ((ext_mdc[s] || ext_mdio_oe[s]) && !(!mon_int && s == mon_id)) quiet_bad = 1'b1;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int unsigned a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input int unsigned a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = AW'(a);
      #1 d = bus_rdata;
   endtask

   function automatic logic [63:0] ef(input logic [1:0] st, input logic [1:0] op,
                                      input logic [4:0] pa, input logic [4:0] ra,
                                      input logic [15:0] d);
      return {32'hFFFF_FFFF, st, op, pa, ra, 2'b10, d};
   endfunction

   task automatic mon_clear();
      nrise = 0; nhigh = 0; quiet_bad = 1'b0;
   endtask

   task automatic wait_done(output bit ok);
      logic [31:0] s;
      ok = 1'b0;
      for (int n = 0; n < 20000; n++) begin
         rd(32'h24C, s);
         if (s[0]) begin ok = 1'b1; break; end
      end
   endtask

   // compare the captured bits against the expected frames
   task automatic cmp_frames(input int nfr, input logic [63:0] e0, input logic [63:0] o0,
                             input logic [63:0] e1, input logic [63:0] o1, input string req);
      int bad = -1;
      for (int f = 0; f < nfr; f++) begin
         for (int i = 0; i < 64; i++) begin
            logic eb, eo;
            eb = (f == 0) ? e0[63-i] : e1[63-i];
            eo = (f == 0) ? o0[63-i] : o1[63-i];
            if (bad < 0 && (cap_oe[f*64+i] !== eo || (eo && cap_o[f*64+i] !== eb)))
               bad = f*64+i;
         end
      end
      chk(bad < 0, req, 64'(bad), 64'hFFFF_FFFF_FFFF_FFFF);
   endtask

   task automatic run_txn(input bit isint, input int id, input logic [4:0] phy,
                          input logic [20:0] ad, input bit c45, input bit isrd,
                          input logic [15:0] wd, input logic [15:0] dv,
                          input logic [7:0] md, input logic [15:0] resp);
      logic [31:0] r;
      logic [63:0] e0, o0, e1, o1;
      int nfr, h;
      bit ok;
      h   = ((dv == 0) ? 1 : int'(dv)) * (int'(md) + 1);
      nfr = c45 ? 2 : 1;
      wr(isint ? 32'h004 : 32'h000, {8'h0, md, dv});
      wr(isint ? 32'h000 : 32'h004, {8'h0, 8'd3, 16'd5});
      wr(32'h23C, {6'h0, isint, 3'(id), c45, phy, wd});
      wr(32'h244, {11'h0, ad});
      mon_int = isint; mon_id = id; rv = resp;
      mon_clear();
      wr(32'h248, isrd ? 32'd2 : 32'd1);
      wait_done(ok);
      chk(ok, "R6 done after transaction", 64'(ok), 64'd1);
      o1 = '1; e1 = '0;
      if (c45) begin
         e0 = ef(2'b00, 2'b00, phy, ad[20:16], ad[15:0]);
         o0 = '1;
         e1 = ef(2'b00, isrd ? 2'b11 : 2'b01, phy, ad[20:16], isrd ? 16'h0 : wd);
         o1 = isrd ? {46'h3FFF_FFFF_FFFF, 18'h0} : '1;
         cmp_frames(2, e0, o0, e1, o1, isrd ? "R5 R4 c45 read frames" : "R5 c45 write frames");
      end else begin
         e0 = ef(2'b01, isrd ? 2'b10 : 2'b01, phy, ad[4:0], isrd ? 16'h0 : wd);
         o0 = isrd ? {46'h3FFF_FFFF_FFFF, 18'h0} : '1;
         cmp_frames(1, e0, o0, e1, o1, isrd ? "R4 c22 read frame" : "R3 c22 write frame");
      end
      chk(nrise == nfr*64, "R8 rising MDC edges", 64'(nrise), 64'(nfr*64));
      chk(nhigh == nfr*64*h, "R8 MDC high time", 64'(nhigh), 64'(nfr*64*h));
      chk(!quiet_bad, "R7 unselected segments quiet", 64'(quiet_bad), 64'd0);
      if (isrd) begin
         rd(32'h240, r);
         chk(r == {16'h0, resp}, "R4 R7 read data", 64'(r), 64'({16'h0, resp}));
      end
      wr(32'h248, 32'd0);
      rd(32'h24C, r);
      chk(r[0] == 1'b0, "R6 clear done", 64'(r), 64'd0);
   endtask

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         fails++;
         $display("FAIL R6 watchdog actual=hung expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [31:0] r;
      bit ok;
      void'($urandom(32'd24601));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(32'h24C, r); chk(r == 0, "R1 status after reset", 64'(r), 64'd0);
      rd(32'h23C, r); chk(r == 0, "R1 config after reset", 64'(r), 64'd0);
      chk({int_mdc, int_mdio_oe, ext_mdc, ext_mdio_oe, ext_lockout} == '0,
          "R1 segments idle after reset",
          64'({int_mdc, int_mdio_oe, ext_mdc, ext_mdio_oe, ext_lockout}), 64'd0);

      // R2 readback and lockout
      wr(32'h000, 32'h0001_0004); rd(32'h000, r);
      chk(r == 32'h0001_0004, "R2 ext rate readback", 64'(r), 64'h0001_0004);
      wr(32'h244, 32'h001F_ABCD); rd(32'h244, r);
      chk(r == 32'h001F_ABCD, "R2 address readback", 64'(r), 64'h001F_ABCD);
      wr(32'h008, 32'h1000_0000); rd(32'h008, r);
      chk(r == 32'h1000_0000 && ext_lockout, "R2 lockout set", 64'({ext_lockout, r}), 64'h1_1000_0000);
      wr(32'h008, 32'h0);
      chk(!ext_lockout, "R2 lockout clear", 64'(ext_lockout), 64'd0);

      // directed corner cases
      run_txn(1'b1, 0, 5'h00, 21'h0, 1'b0, 1'b0, 16'h0000, 16'd0, 8'd0, 16'h0);
      run_txn(1'b0, 7, 5'h1F, 21'h1F_FFFF, 1'b0, 1'b1, 16'hFFFF, 16'd1, 8'd1, 16'hFFFF);
      run_txn(1'b0, 3, 5'h15, 21'h0A_5A5A, 1'b1, 1'b1, 16'h1234, 16'd2, 8'd0, 16'hA5C3);
      run_txn(1'b1, 5, 5'h0A, 21'h15_1234, 1'b1, 1'b0, 16'hBEEF, 16'd0, 8'd2, 16'h0);

      // R9 control writes while busy are ignored
      wr(32'h004, 32'h0000_0002);
      wr(32'h23C, {6'h0, 1'b1, 3'd2, 1'b0, 5'h03, 16'hC0DE});
      wr(32'h244, 32'h0000_0009);
      mon_int = 1'b1; mon_id = 2; mon_clear();
      wr(32'h248, 32'd1);
      repeat (30) @(negedge clk);
      wr(32'h248, 32'd2);
      wr(32'h248, 32'd0);
      wr(32'h248, 32'd1);
      wait_done(ok);
      chk(ok, "R9 done still set after busy writes", 64'(ok), 64'd1);
      cmp_frames(1, ef(2'b01, 2'b01, 5'h03, 5'h09, 16'hC0DE), '1, '0, '1, "R9 write frame unchanged");
      chk(nrise == 64, "R9 no restart", 64'(nrise), 64'd64);
      wr(32'h248, 32'd0);

      // R9 invalid control value
      mon_clear();
      wr(32'h248, 32'd3);
      repeat (40) @(negedge clk);
      rd(32'h24C, r);
      chk(nrise == 0 && r[0] == 1'b0, "R9 invalid op ignored", 64'({nrise, r}), 64'd0);

      // constrained random transactions
      for (int t = 0; t < 26; t++) begin
         run_txn(1'($urandom), int'($urandom % NS), 5'($urandom), 21'($urandom),
                 1'($urandom), 1'($urandom), 16'($urandom),
                 16'($urandom % 4), 8'($urandom % 3), 16'($urandom));
      end

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule